// File: doc/BRIEF.md
# Capture/Compare Channel Array

This block holds a parameterised number of timer channels that all watch one shared counter value supplied from outside. Each channel works either as an input capture, which records the counter value when its pin shows a selected edge, or as an output compare, which changes its pin when the counter reaches the value in its register. The highest-numbered channel can also act as a master. When it matches, it drives the pins of any compare channels selected by a mask to fixed levels taken from a data register.

Three more pin actions sit beside the plain compare: a forced compare started by software, a toggle when the counter wraps, and the master override. When several of them fall in one cycle, a fixed priority decides which one is applied. Every channel has a flag, which is set by a capture or a real match, and an interrupt enable. Flags are cleared by writing ones. An optional fast-clear mode also clears a flag as a side effect of accessing that channel's data register. Software reaches all state through a simple synchronous register port, and read data comes back one cycle after the request.

Top module: `capcmp_array`

## Requirements
- R1: After reset, every channel register, flag, pin output, pin enable and interrupt is 0.
- R2: The action field of channel i sits at bits [2i+1:2i] of the action register (address 5). On a match it does the following in the next cycle: 00 leaves the pin alone, 01 inverts it, 10 drives it low and 11 drives it high. A match sets the channel flag whatever the action.
- R3: A compare channel (bit i of the mode register, address 0, equal to 1) matches only in a cycle where `cnt_adv` is high and `cnt_in` equals its register (address 16+i). An equal counter without `cnt_adv` does nothing.
- R4: A capture channel (mode bit 0) has an edge field at bits [2i+1:2i] of the edge register (address 6): 00 off, 01 rising, 10 falling, 11 either edge. On a selected edge it copies `cnt_in` into its register and sets its flag. Writes to its register are ignored.
- R5: Writing 1 to bit i of the force register (address 1) applies the compare action of channel i at once without setting its flag. The force register always reads 0.
- R6: When a force and a real match hit the same channel in the same cycle, the action is applied exactly once and the flag stays clear.
- R7: When channel N-1 is in compare mode and matches, every compare channel whose bit is set in the mask register (address 2) drives its pin to its bit in the data register (address 3). This takes precedence over all other actions on that pin.
- R8: With bit i of the wrap-toggle register (address 4) set, a `cnt_ovf` pulse inverts the pin of compare channel i. This takes precedence over a force and yields to the override of R7.
- R9: The flag register (address 8) reads the flags. Writing 1 to a bit clears it, and writing 0 has no effect.
- R10: With bit 0 of the control register (address 9) set, reading the register of a capture channel or writing the register of a compare channel clears that channel's flag. Reading the register of a compare channel does not.
- R11: `irq[i]` is high exactly when flag i and bit i of the enable register (address 7) are both set.
- R12: A pin change presented before a clock edge raises the capture flag at the third rising edge. Read data appears on `rdata` one cycle after `rd_en`.
- R13: `pin_oe[i]` is high when channel i is in compare mode and either its action field is nonzero or its mask bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_in | input | W | Shared counter value |
| cnt_adv | input | 1 | Counter took a new value this cycle |
| cnt_ovf | input | 1 | Counter wrapped this cycle |
| pin_in | input | N | Channel pin inputs (asynchronous) |
| pin_out | output | N | Channel pin output levels |
| pin_oe | output | N | Channel pin output enables |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Register address |
| wdata | input | W | Write data |
| rdata | output | W | Read data, registered |
| irq | output | N | Per-channel interrupt requests |

## Verification
The bench builds the block with its defaults: eight channels, a 16-bit counter and a 5-bit address. With these values the override source is channel 7, and each 2-bit-per-channel field fills a whole data word, so the top field positions are exercised. A 16-bit counter also lets the compare vectors use values that differ only in the low bit, so a match on one value is shown against a near miss on the next.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;

  typedef enum logic [1:0] {
    ACT_KEEP   = 2'b00,
    ACT_INVERT = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_HIGH   = 2'b11
  } cmp_act_e;

  localparam int unsigned RA_MODE  = 0;
  localparam int unsigned RA_FORCE = 1;
  localparam int unsigned RA_MASK  = 2;
  localparam int unsigned RA_DATA  = 3;
  localparam int unsigned RA_WRAP  = 4;
  localparam int unsigned RA_ACT   = 5;
  localparam int unsigned RA_EDGE  = 6;
  localparam int unsigned RA_IEN   = 7;
  localparam int unsigned RA_FLAGS = 8;
  localparam int unsigned RA_CTRL  = 9;
  localparam int unsigned RA_CHAN  = 16;

  function automatic logic apply_act(input logic [1:0] a, input logic cur);
    case (cmp_act_e'(a))
      ACT_INVERT: return ~cur;
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      default:    return cur;
    endcase
  endfunction

endpackage

// File: rtl/capcmp_insync.sv
module capcmp_insync #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_in,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise = sync_q & ~prev_q;
  assign fall = ~sync_q & prev_q;
endmodule

// File: rtl/capcmp_chan.sv
module capcmp_chan import capcmp_pkg::*; #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cnt,
  input  logic         cnt_adv,
  input  logic         cnt_ovf,
  input  logic         is_cmp,
  input  logic [1:0]   act,
  input  logic [1:0]   edg,
  input  logic         wrap_en,
  input  logic         ovr_hit,
  input  logic         ovr_val,
  input  logic         force_i,
  input  logic         rise,
  input  logic         fall,
  input  logic         reg_wr,
  input  logic [W-1:0] wdata,
  input  logic         flag_clr,
  output logic [W-1:0] value,
  output logic         flag,
  output logic         pin
);
  logic match, cap;

  assign match = is_cmp & cnt_adv & (cnt == value);
  assign cap   = ~is_cmp & ((edg[0] & rise) | (edg[1] & fall));

  always_ff @(posedge clk) begin
    if (rst) begin
      value <= '0;
      flag  <= 1'b0;
      pin   <= 1'b0;
    end else begin
      if (cap)                  value <= cnt;
      else if (is_cmp && reg_wr) value <= wdata;

      if ((match && !force_i) || cap) flag <= 1'b1;
      else if (flag_clr)              flag <= 1'b0;

      if (is_cmp) begin
        if (ovr_hit)                pin <= ovr_val;
        else if (wrap_en && cnt_ovf) pin <= ~pin;
        else if (force_i || match)  pin <= apply_act(act, pin);
      end
    end
  end
endmodule

// File: rtl/capcmp_array.sv
module capcmp_array import capcmp_pkg::*; #(
  parameter int N  = 8,
  parameter int W  = 16,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  cnt_in,
  input  logic          cnt_adv,
  input  logic          cnt_ovf,
  input  logic [N-1:0]  pin_in,
  output logic [N-1:0]  pin_out,
  output logic [N-1:0]  pin_oe,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic [N-1:0]  irq
);
  localparam int AN = 2 * N;

  logic [N-1:0]        mode_q, mask_q, data_q, wrap_q, ie_q;
  logic [AN-1:0]       act_q, edg_q;
  logic                fast_q;
  logic [N-1:0][W-1:0] ch_val;
  logic [N-1:0]        flag_v, force_v, rise_v, fall_v, chan_sel, clr_v, ovr_hit;
  logic                hit7;
  logic                wr_flags;
  logic [W-1:0]        rd_mux;

  function automatic logic at(input logic [AW-1:0] a, input int unsigned r);
    return a == AW'(r);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0; mask_q <= '0; data_q <= '0; wrap_q <= '0; ie_q <= '0;
      act_q  <= '0; edg_q  <= '0; fast_q <= 1'b0;
    end else if (wr_en) begin
      if (at(addr, RA_MODE)) mode_q <= wdata[N-1:0];
      if (at(addr, RA_MASK)) mask_q <= wdata[N-1:0];
      if (at(addr, RA_DATA)) data_q <= wdata[N-1:0];
      if (at(addr, RA_WRAP)) wrap_q <= wdata[N-1:0];
      if (at(addr, RA_IEN))  ie_q   <= wdata[N-1:0];
      if (at(addr, RA_ACT))  act_q  <= wdata[AN-1:0];
      if (at(addr, RA_EDGE)) edg_q  <= wdata[AN-1:0];
      if (at(addr, RA_CTRL)) fast_q <= wdata[0];
    end
  end

  assign force_v  = (wr_en && at(addr, RA_FORCE)) ? wdata[N-1:0] : '0;
  assign wr_flags = wr_en && at(addr, RA_FLAGS);
  assign hit7     = mode_q[N-1] & cnt_adv & (cnt_in == ch_val[N-1]);
  assign ovr_hit  = mask_q & {N{hit7}};

  capcmp_insync #(.N(N)) u_sync (
    .clk(clk), .rst(rst), .pin_in(pin_in), .rise(rise_v), .fall(fall_v)
  );

  for (genvar i = 0; i < N; i++) begin : g_ch
    assign chan_sel[i] = at(addr, RA_CHAN + i);
    assign clr_v[i]    = (wr_flags & wdata[i]) |
                         (fast_q & chan_sel[i] &
                          ((rd_en & ~mode_q[i]) | (wr_en & mode_q[i])));
    assign pin_oe[i]   = mode_q[i] & ((act_q[2*i +: 2] != 2'b00) | mask_q[i]);

    capcmp_chan #(.W(W)) u_chan (
      .clk(clk), .rst(rst), .cnt(cnt_in), .cnt_adv(cnt_adv), .cnt_ovf(cnt_ovf),
      .is_cmp(mode_q[i]), .act(act_q[2*i +: 2]), .edg(edg_q[2*i +: 2]),
      .wrap_en(wrap_q[i]), .ovr_hit(ovr_hit[i]), .ovr_val(data_q[i]),
      .force_i(force_v[i]), .rise(rise_v[i]), .fall(fall_v[i]),
      .reg_wr(wr_en & chan_sel[i]), .wdata(wdata), .flag_clr(clr_v[i]),
      .value(ch_val[i]), .flag(flag_v[i]), .pin(pin_out[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (at(addr, RA_MODE))  rd_mux = W'(mode_q);
    if (at(addr, RA_MASK))  rd_mux = W'(mask_q);
    if (at(addr, RA_DATA))  rd_mux = W'(data_q);
    if (at(addr, RA_WRAP))  rd_mux = W'(wrap_q);
    if (at(addr, RA_IEN))   rd_mux = W'(ie_q);
    if (at(addr, RA_ACT))   rd_mux = W'(act_q);
    if (at(addr, RA_EDGE))  rd_mux = W'(edg_q);
    if (at(addr, RA_FLAGS)) rd_mux = W'(flag_v);
    if (at(addr, RA_CTRL))  rd_mux = W'(fast_q);
    for (int k = 0; k < N; k++)
      if (chan_sel[k]) rd_mux = ch_val[k];
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  assign irq = flag_v & ie_q;
endmodule

// File: rtl/capcmp_array_chk.sv
module capcmp_array_chk import capcmp_pkg::*; #(
  parameter int N  = 8,
  parameter int W  = 16,
  parameter int AW = 5
) (
  input logic                clk,
  input logic                rst,
  input logic                rd_en,
  input logic                wr_en,
  input logic [AW-1:0]       addr,
  input logic [W-1:0]        wdata,
  input logic [W-1:0]        rdata,
  input logic                cnt_adv,
  input logic [N-1:0]        pin_out,
  input logic [N-1:0]        mode_q,
  input logic [2*N-1:0]      edg_q,
  input logic [N-1:0]        mask_q,
  input logic [N-1:0]        data_q,
  input logic [N-1:0]        flag_v,
  input logic [N-1:0]        force_v,
  input logic                hit7,
  input logic [N-1:0][W-1:0] ch_val
);
  assert_force_reads_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == AW'(RA_FORCE)) |=> (rdata == '0));

  for (genvar i = 0; i < N; i++) begin : g_chk
    assert_capture_write_ignored_R4: assert property (@(posedge clk) disable iff (rst)
      (!mode_q[i] && edg_q[2*i +: 2] == 2'b00) |=> $stable(ch_val[i]));

    assert_force_no_flag_R6: assert property (@(posedge clk) disable iff (rst)
      (mode_q[i] && force_v[i] && !flag_v[i]) |=> !flag_v[i]);

    assert_flag_clear_R9: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == AW'(RA_FLAGS) && wdata[i] && !cnt_adv &&
       (mode_q[i] || edg_q[2*i +: 2] == 2'b00)) |=> !flag_v[i]);

    assert_override_level_R7: assert property (@(posedge clk) disable iff (rst)
      (hit7 && mask_q[i] && mode_q[i]) |=> (pin_out[i] == $past(data_q[i])));
  end
endmodule

bind capcmp_array capcmp_array_chk #(.N(N), .W(W), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .cnt_adv(cnt_adv), .pin_out(pin_out),
  .mode_q(mode_q), .edg_q(edg_q), .mask_q(mask_q), .data_q(data_q),
  .flag_v(flag_v), .force_v(force_v), .hit7(hit7), .ch_val(ch_val)
);

// File: tb/capcmp_array_bench.sv
module capcmp_array_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_MODE = 5'd0, A_FORCE = 5'd1, A_MASK = 5'd2, A_DATA = 5'd3,
                         A_WRAP = 5'd4, A_ACT = 5'd5, A_EDGE = 5'd6, A_IEN = 5'd7,
                         A_FLAGS = 5'd8, A_CTRL = 5'd9, A_CH0 = 5'd16;

  // {adv, action, counter value, expected pin 0, expected flag 0}
  localparam logic [20:0] VEC [10] = '{
    {1'b1, 2'b11, 16'h0100, 1'b1, 1'b1},
    {1'b1, 2'b10, 16'h0100, 1'b0, 1'b1},
    {1'b1, 2'b01, 16'h0100, 1'b1, 1'b1},
    {1'b1, 2'b01, 16'h0100, 1'b0, 1'b1},
    {1'b1, 2'b01, 16'h00FF, 1'b0, 1'b0},
    {1'b1, 2'b00, 16'h0100, 1'b0, 1'b1},
    {1'b1, 2'b11, 16'h0101, 1'b0, 1'b0},
    {1'b0, 2'b11, 16'h0100, 1'b0, 1'b0},
    {1'b1, 2'b11, 16'h0100, 1'b1, 1'b1},
    {1'b0, 2'b01, 16'h0100, 1'b1, 1'b0}
  };

  logic        clk = 1'b0, rst = 1'b1;
  logic [15:0] cnt_in = '0;
  logic        cnt_adv = 1'b0, cnt_ovf = 1'b0;
  logic [7:0]  pin_in = '0;
  logic [7:0]  pin_out, pin_oe, irq;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0, rdata, rv;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  capcmp_array u_capcmp_array (
    .clk(clk), .rst(rst), .cnt_in(cnt_in), .cnt_adv(cnt_adv), .cnt_ovf(cnt_ovf),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  task automatic tick(input logic [15:0] v, input logic adv, input logic ovf);
    @(negedge clk); cnt_in = v; cnt_adv = adv; cnt_ovf = ovf;
    @(negedge clk); cnt_adv = 1'b0; cnt_ovf = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    settle(3);
    rst = 1'b0;
    // R1 reset state
    chk("R1 pins", pin_out, 0);
    chk("R1 oe", pin_oe, 0);
    chk("R1 irq", irq, 0);
    rd(A_CH0, rv); chk("R1 ch0 reg", rv, 0);

    // R2 R3 compare vectors on channel 0
    wr(A_MODE, 16'h0001);
    wr(A_CH0, 16'h0100);
    wr(A_IEN, 16'h0001);
    for (int k = 0; k < 10; k++) begin
      wr(A_ACT, {14'd0, VEC[k][19:18]});
      wr(A_FLAGS, 16'h0001);
      tick(VEC[k][17:2], VEC[k][20], 1'b0);
      chk("R2 R3 pin", pin_out[0], VEC[k][1]);
      chk("R2 R3 flag", irq[0], VEC[k][0]);
    end

    // R4 R12 capture on channel 1, rising only
    wr(A_EDGE, 16'h0004);
    wr(A_IEN, 16'h0003);
    @(negedge clk); cnt_in = 16'h1234; pin_in[1] = 1'b1;
    @(negedge clk); chk("R12 edge1", irq[1], 0);
    @(negedge clk); chk("R12 edge2", irq[1], 0);
    @(negedge clk); chk("R12 edge3", irq[1], 1);
    rd(A_CH0 + 5'd1, rv); chk("R4 captured", rv, 16'h1234);
    cnt_in = 16'h5555; pin_in[1] = 1'b0; settle(4);
    rd(A_CH0 + 5'd1, rv); chk("R4 falling ignored", rv, 16'h1234);
    wr(A_CH0 + 5'd1, 16'hBEEF);
    rd(A_CH0 + 5'd1, rv); chk("R4 write ignored", rv, 16'h1234);
    chk("R13 capture oe", pin_oe[1], 0);
    wr(A_EDGE, 16'h0008);
    pin_in[1] = 1'b1; settle(4);
    cnt_in = 16'h7777; pin_in[1] = 1'b0; settle(4);
    rd(A_CH0 + 5'd1, rv); chk("R4 falling capture", rv, 16'h7777);

    // R9 write-one-to-clear
    wr(A_FLAGS, 16'h0000);
    rd(A_FLAGS, rv); chk("R9 zero write keeps", rv[1], 1);
    wr(A_FLAGS, 16'h0002);
    rd(A_FLAGS, rv); chk("R9 one write clears", rv[1], 0);

    // R11 enable gating
    wr(A_EDGE, 16'h000C);
    cnt_in = 16'h1111; pin_in[1] = 1'b1; settle(4);
    wr(A_IEN, 16'h0001);
    chk("R11 masked irq", irq[1], 0);
    rd(A_FLAGS, rv); chk("R11 flag set", rv[1], 1);
    wr(A_IEN, 16'h0003);
    chk("R11 enabled irq", irq[1], 1);

    // R10 fast clear
    wr(A_CTRL, 16'h0001);
    rd(A_CH0 + 5'd1, rv); chk("R10 capture read clears", irq[1], 0);
    wr(A_ACT, 16'h0003);
    tick(16'h0100, 1'b1, 1'b0); chk("R10 match flag", irq[0], 1);
    rd(A_CH0, rv); chk("R10 compare read keeps", irq[0], 1);
    wr(A_CH0, 16'h0100); chk("R10 compare write clears", irq[0], 0);
    wr(A_CTRL, 16'h0000);

    // R5 force on channel 2
    wr(A_MODE, 16'h0005);
    wr(A_ACT, 16'h0033);
    wr(A_IEN, 16'h0005);
    wr(A_FORCE, 16'h0004);
    chk("R5 force pin", pin_out[2], 1);
    chk("R5 force no flag", irq[2], 0);
    rd(A_FORCE, rv); chk("R5 reads zero", rv, 0);

    // R6 force and match together on channel 3
    wr(A_MODE, 16'h000D);
    wr(A_CH0 + 5'd3, 16'h0200);
    wr(A_ACT, 16'h0073);
    wr(A_IEN, 16'h000D);
    @(negedge clk); wr_en = 1'b1; addr = A_FORCE; wdata = 16'h0008;
    cnt_in = 16'h0200; cnt_adv = 1'b1;
    @(negedge clk); wr_en = 1'b0; cnt_adv = 1'b0;
    chk("R6 single toggle", pin_out[3], 1);
    chk("R6 no flag", irq[3], 0);
    tick(16'h0200, 1'b1, 1'b0);
    chk("R6 plain match pin", pin_out[3], 0);
    chk("R6 plain match flag", irq[3], 1);

    // R7 override from channel 7
    wr(A_MODE, 16'h009D);
    wr(A_CH0, 16'h0300);
    wr(A_CH0 + 5'd4, 16'h0300);
    wr(A_CH0 + 5'd7, 16'h0300);
    wr(A_ACT, 16'h0373);
    wr(A_MASK, 16'h0081);
    wr(A_DATA, 16'h0080);
    chk("R13 mask oe", pin_oe[7], 1);
    chk("R7 pin0 before", pin_out[0], 1);
    tick(16'h0300, 1'b1, 1'b0);
    chk("R7 override beats own", pin_out[0], 0);
    chk("R7 master pin", pin_out[7], 1);
    chk("R7 unmasked own action", pin_out[4], 1);

    // R8 toggle on wrap, channel 5
    wr(A_MASK, 16'h0000);
    wr(A_MODE, 16'h00BD);
    wr(A_WRAP, 16'h0020);
    tick(16'h0000, 1'b1, 1'b1);
    chk("R8 wrap toggle", pin_out[5], 1);
    wr(A_ACT, 16'h0F73);
    @(negedge clk); wr_en = 1'b1; addr = A_FORCE; wdata = 16'h0020; cnt_ovf = 1'b1;
    @(negedge clk); wr_en = 1'b0; cnt_ovf = 1'b0;
    chk("R8 wrap beats force", pin_out[5], 0);
    tick(16'h0000, 1'b0, 1'b1);
    chk("R8 wrap toggle again", pin_out[5], 1);
    wr(A_CH0 + 5'd7, 16'h0000);
    wr(A_MASK, 16'h0020);
    wr(A_DATA, 16'h0020);
    tick(16'h0000, 1'b1, 1'b1);
    chk("R8 override beats wrap", pin_out[5], 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule